// File: doc/BRIEF.md
# Trace Output Configuration Registers

This block holds the configuration state of a trace output unit behind a simple 32-bit read/write bus. Software uses it to choose the output protocol, the serial baud divisor and the port width. It also reads back the fixed capability values, and it reserves the trace unit through a small claim tag. The chosen settings drive the output pins straight away, where the serial encoder and the formatter pick them up.

Most registers are ordinary stored fields. Three of them behave otherwise. The claim tag uses one address to set bits and another to clear them, and reads at those same addresses return the mask and the current tag. The formatter control readback is overridden while parallel trace mode is selected. The device identifier depends on a build parameter that says whether an instruction trace source is present.

Top module: `trace_cfg_regs`

## Requirements
- R1: After reset the reads return these values. Width capability (0x000) is 0xB, width select (0x004) is 0x1, divisor (0x010) is 0 and protocol (0x0F0) is 1. Formatter status (0x300) is 0x8, formatter control (0x304) is 0x102 and the sync counter (0x308) is 0. The claim mask (0xFA0) is 0xF, the claim tag (0xFA4) is 0 and the identifier (0xFC8) is 0xCA0.
- R2: `bus_rdata` is loaded on the clock edge where `bus_rd` is high, and it holds its value on all other edges. If a write to the same address happens in that same cycle, the read returns the value from before the write.
- R3: Writes to the capability, formatter status, sync counter and identifier addresses change nothing.
- R4: A write to 0x004 stores bits 3:0, and `width_sel` shows them. `width_err` is high while the stored value has more than one bit set or has bit 2 set.
- R5: A write to 0x010 stores bits 12:0 in the divisor field, which `presc_div` shows. Higher bits are dropped.
- R6: A write to 0x0F0 stores bits 1:0, which `proto_sel` shows. The encodings are 0 for parallel, 1 for Manchester serial and 2 for NRZ serial.
- R7: A write to 0x304 stores bit 8 (trigger insertion) and bit 1 (continuous formatting). While the protocol is 0, reads return 0x102 and both `trig_insert_en` and `fmt_cont_en` are 1. Otherwise the reads and the outputs show the stored bits.
- R8: A write to 0xFA0 sets each claim tag bit that is written as 1.
- R9: A write to 0xFA4 clears each claim tag bit that is written as 1. Tag bits above bit 3 are ignored on both the set and the clear address.
- R10: The identifier reads 0xCA1 when `HAS_INSN_TRACE` is 1.
- R11: Any other address reads 0 and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 12 | Byte address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| proto_sel | output | 2 | Selected output protocol |
| presc_div | output | 13 | Baud divisor minus one |
| width_sel | output | 4 | Selected port width, one-hot |
| width_err | output | 1 | Stored width value is invalid |
| fmt_cont_en | output | 1 | Continuous formatting in effect |
| trig_insert_en | output | 1 | Trigger insertion in effect |

## Verification
The bench first switches to parallel mode and writes new formatter control bits while that mode is selected. It then switches back to a serial mode. A design that overwrites the stored value with the forced value, or that forgets to apply the override, shows the wrong readback or the wrong outputs at one of these steps. It also drives set and clear words with upper bits and tag bits that are already in the target state. A design that stores or wraps those upper bits, or that toggles bits instead of setting and clearing them, ends with the wrong tag. Further cases cover invalid width patterns, divisor writes with junk in the upper bits, and a read that coincides with a write to the same address; the last one catches a read path that forwards the new value.

// File: rtl/trace_cfg_regs.sv
module trace_cfg_regs #(
  parameter int AW = 12,
  parameter int PW = 13,
  parameter int TAGW = 4,
  parameter bit HAS_INSN_TRACE = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_wr,
  input  logic [31:0]   bus_wdata,
  input  logic          bus_rd,
  output logic [31:0]   bus_rdata,
  output logic [1:0]    proto_sel,
  output logic [PW-1:0] presc_div,
  output logic [3:0]    width_sel,
  output logic          width_err,
  output logic          fmt_cont_en,
  output logic          trig_insert_en
);
  localparam logic [AW-1:0] A_CAP   = AW'('h000);
  localparam logic [AW-1:0] A_WID   = AW'('h004);
  localparam logic [AW-1:0] A_DIV   = AW'('h010);
  localparam logic [AW-1:0] A_PROTO = AW'('h0F0);
  localparam logic [AW-1:0] A_FSTAT = AW'('h300);
  localparam logic [AW-1:0] A_FCTL  = AW'('h304);
  localparam logic [AW-1:0] A_SYNC  = AW'('h308);
  localparam logic [AW-1:0] A_CSET  = AW'('hFA0);
  localparam logic [AW-1:0] A_CCLR  = AW'('hFA4);
  localparam logic [AW-1:0] A_ID    = AW'('hFC8);
  localparam logic [31:0] CAP_VAL   = 32'h0000_000B;
  localparam logic [31:0] FSTAT_VAL = 32'h0000_0008;
  localparam logic [31:0] FCTL_PAR  = 32'h0000_0102;
  localparam logic [31:0] ID_VAL    = HAS_INSN_TRACE ? 32'h0000_0CA1 : 32'h0000_0CA0;
  localparam logic [31:0] MASK_VAL  = 32'((64'd1 << TAGW) - 1);

  logic [TAGW-1:0] tag_q;
  logic            trig_q, cont_q;
  logic [31:0]     fctl_rd, rd_mux;
  logic            par_mode;

  assign par_mode       = (proto_sel == 2'd0);
  assign fmt_cont_en    = par_mode | cont_q;
  assign trig_insert_en = par_mode | trig_q;
  assign fctl_rd        = par_mode ? FCTL_PAR : {23'd0, trig_q, 6'd0, cont_q, 1'b0};
  assign width_err      = width_sel[2] | ($countones(width_sel) > 1);

  always_comb begin
    case (bus_addr)
      A_CAP:   rd_mux = CAP_VAL;
      A_WID:   rd_mux = {28'd0, width_sel};
      A_DIV:   rd_mux = 32'(presc_div);
      A_PROTO: rd_mux = {30'd0, proto_sel};
      A_FSTAT: rd_mux = FSTAT_VAL;
      A_FCTL:  rd_mux = fctl_rd;
      A_SYNC:  rd_mux = 32'd0;
      A_CSET:  rd_mux = MASK_VAL;
      A_CCLR:  rd_mux = 32'(tag_q);
      A_ID:    rd_mux = ID_VAL;
      default: rd_mux = 32'd0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      width_sel <= 4'h1;
      presc_div <= '0;
      proto_sel <= 2'd1;
      trig_q    <= 1'b1;
      cont_q    <= 1'b1;
      tag_q     <= '0;
      bus_rdata <= '0;
    end else begin
      if (bus_rd) bus_rdata <= rd_mux;
      if (bus_wr) begin
        case (bus_addr)
          A_WID:   width_sel <= bus_wdata[3:0];
          A_DIV:   presc_div <= bus_wdata[PW-1:0];
          A_PROTO: proto_sel <= bus_wdata[1:0];
          A_FCTL: begin
            trig_q <= bus_wdata[8];
            cont_q <= bus_wdata[1];
          end
          A_CSET:  tag_q <= tag_q | bus_wdata[TAGW-1:0];
          A_CCLR:  tag_q <= tag_q & ~bus_wdata[TAGW-1:0];
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/trace_cfg_regs_chk.sv
module trace_cfg_regs_chk #(
  parameter int AW = 12,
  parameter int PW = 13
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] bus_addr,
  input logic          bus_wr,
  input logic [31:0]   bus_wdata,
  input logic          bus_rd,
  input logic [31:0]   bus_rdata,
  input logic [1:0]    proto_sel,
  input logic [PW-1:0] presc_div,
  input logic [3:0]    width_sel,
  input logic          fmt_cont_en,
  input logic          trig_insert_en
);
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !bus_rd |=> $stable(bus_rdata)); // R2
  AST_WIDTH_WRITE: assert property (@(posedge clk) disable iff (!rst_n) (bus_wr && bus_addr == AW'('h004)) |=> width_sel == $past(bus_wdata[3:0])); // R4
  AST_DIV_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !(bus_wr && bus_addr == AW'('h010)) |=> $stable(presc_div)); // R5
  AST_PROTO_WRITE: assert property (@(posedge clk) disable iff (!rst_n) (bus_wr && bus_addr == AW'('h0F0)) |=> proto_sel == $past(bus_wdata[1:0])); // R6
  AST_PAR_FORCE: assert property (@(posedge clk) disable iff (!rst_n) (proto_sel == 2'd0) |-> (fmt_cont_en && trig_insert_en)); // R7
endmodule

bind trace_cfg_regs trace_cfg_regs_chk #(.AW(AW), .PW(PW)) u_chk (.*);

// File: tb/trace_cfg_regs_test.sv
module trace_cfg_regs_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [11:0] bus_addr = '0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata, rdata_t;
  logic [1:0] proto_sel, proto_t;
  logic [12:0] presc_div, presc_t;
  logic [3:0] width_sel, width_t;
  logic width_err, cont_en, trig_en, err_t, cont_t, trig_t;
  int n_chk = 0, n_fail = 0, cyc = 0;
  bit done = 0;

  always #2 clk = ~clk;

  trace_cfg_regs uut (.clk, .rst_n, .bus_addr, .bus_wr, .bus_wdata, .bus_rd, .bus_rdata,
    .proto_sel, .presc_div, .width_sel, .width_err, .fmt_cont_en(cont_en), .trig_insert_en(trig_en));
  trace_cfg_regs #(.HAS_INSN_TRACE(1'b1)) uut_tr (.clk, .rst_n, .bus_addr, .bus_wr, .bus_wdata,
    .bus_rd, .bus_rdata(rdata_t), .proto_sel(proto_t), .presc_div(presc_t), .width_sel(width_t),
    .width_err(err_t), .fmt_cont_en(cont_t), .trig_insert_en(trig_t));

  // behavioural reference
  int m_w, m_div, m_proto, m_trig, m_cont, m_tag, m_rd;
  function automatic int m_read(int a);
    case (a)
      'h000: return 'hB;
      'h004: return m_w;
      'h010: return m_div;
      'h0F0: return m_proto;
      'h300: return 8;
      'h304: return (m_proto == 0) ? 'h102 : (m_trig * 256 + m_cont * 2);
      'hFA0: return 'hF;
      'hFA4: return m_tag;
      'hFC8: return 'hCA0;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_w = 1; m_div = 0; m_proto = 1; m_trig = 1; m_cont = 1; m_tag = 0; m_rd = 0;
    end else begin
      if (bus_rd) m_rd = m_read(int'(bus_addr));
      if (bus_wr) begin
        case (int'(bus_addr))
          'h004: m_w = bus_wdata % 16;
          'h010: m_div = bus_wdata % 8192;
          'h0F0: m_proto = bus_wdata % 4;
          'h304: begin m_trig = (bus_wdata >> 8) % 2; m_cont = (bus_wdata >> 1) % 2; end
          'hFA0: m_tag = m_tag | (bus_wdata % 16);
          'hFA4: m_tag = m_tag & ~(bus_wdata % 16);
          default: ;
        endcase
      end
      cyc++;
    end
  end

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    int ones;
    ones = (m_w % 2) + (m_w / 2 % 2) + (m_w / 4 % 2) + (m_w / 8 % 2);
    check("R2 rdata", int'(bus_rdata), m_rd);
    check("R4 width_sel", int'(width_sel), m_w);
    check("R4 width_err", int'(width_err), (ones > 1 || (m_w / 4 % 2) == 1) ? 1 : 0);
    check("R5 presc_div", int'(presc_div), m_div);
    check("R6 proto_sel", int'(proto_sel), m_proto);
    check("R7 fmt_cont_en", int'(cont_en), (m_proto == 0) ? 1 : m_cont);
    check("R7 trig_insert_en", int'(trig_en), (m_proto == 0) ? 1 : m_trig);
  end

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk); bus_addr = 12'(a); bus_wdata = d; bus_wr = 1;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(string req, int a, int exp);
    @(negedge clk); bus_addr = 12'(a); bus_rd = 1;
    @(negedge clk); bus_rd = 0;
    check(req, int'(bus_rdata), exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    rd("R1 cap", 'h000, 'hB);       rd("R1 width", 'h004, 1);
    rd("R1 div", 'h010, 0);         rd("R1 proto", 'h0F0, 1);
    rd("R1 fstat", 'h300, 8);       rd("R1 fctl", 'h304, 'h102);
    rd("R1 sync", 'h308, 0);        rd("R1 mask", 'hFA0, 'hF);
    rd("R1 tag", 'hFA4, 0);         rd("R1 id", 'hFC8, 'hCA0);
    rd("R11 unlisted", 'h008, 0);
    wr('h000, 32'hFFFF_FFFF); wr('h300, 32'h0); wr('h308, 32'h1234); wr('hFC8, 32'h5);
    wr('h008, 32'hFFFF_FFFF); wr('h006, 32'h8);
    rd("R3 cap", 'h000, 'hB);   rd("R3 fstat", 'h300, 8);
    rd("R3 sync", 'h308, 0);    rd("R3 id", 'hFC8, 'hCA0);
    rd("R11 unlisted", 'h008, 0); rd("R11 width untouched", 'h004, 1);
    wr('h004, 32'h4); wr('h004, 32'h3); wr('h004, 32'hFFF8); rd("R4 width", 'h004, 8);
    wr('h004, 32'h2);
    wr('h010, 32'hFFFF_FFFF); rd("R5 div", 'h010, 'h1FFF);
    wr('h010, 32'h0000_2005); rd("R5 div", 'h010, 5);
    wr('h304, 32'h0); rd("R7 fctl serial", 'h304, 0);
    wr('h0F0, 32'h0); rd("R7 fctl parallel", 'h304, 'h102);
    wr('h304, 32'h100); rd("R7 fctl write in parallel", 'h304, 'h102);
    wr('h0F0, 32'h6); rd("R6 proto", 'h0F0, 2); rd("R7 fctl restored", 'h304, 'h100);
    wr('hFA0, 32'hFFFF_FFF5); rd("R8 set", 'hFA4, 5);
    wr('hFA0, 32'h2); rd("R8 set again", 'hFA4, 7);
    wr('hFA4, 32'hFFFF_FF11); rd("R9 clear", 'hFA4, 6);
    wr('hFA4, 32'h8); rd("R9 clear of zero bit", 'hFA4, 6);
    @(negedge clk); bus_addr = 12'h010; bus_wdata = 32'h77; bus_wr = 1; bus_rd = 1;
    @(negedge clk); bus_wr = 0; bus_rd = 0;
    check("R2 read during write", int'(bus_rdata), 5);
    rd("R5 div after", 'h010, 'h77);
    @(negedge clk); bus_addr = 12'hFC8; bus_rd = 1;
    @(negedge clk); bus_rd = 0;
    check("R10 id with trace source", int'(rdata_t), 'hCA1);
    repeat (3) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule